// File: doc/BRIEF.md
# Latched Bidirectional Parity Transceiver

This block joins two byte-laned buses, called side A and side B, each of which carries `LANES` lanes of `DW` data bits plus one parity bit per lane. Each side has its own hold register that acts as a transparent latch. While the enable for a side is high, that side's view follows the bus. While the enable is low, the view keeps the value captured at the last clock edge with the enable high. Two active-low output enables pick which side the block drives. The driven side receives the other side's latched view. In each lane, its parity bit is either passed on unchanged or regenerated from the data byte, using the odd or even sense selected by an input.

Both sides are checked for parity at the same time, and each side has its own active-low flags, one per lane. A driving side's latch reads back the word the block is driving, so the check covers the outgoing word as well as the incoming one. The flag of the receiving side is held inactive while that side's latch is closed. Each bus is modelled as a separate input, output and output-enable. When a side is not driven, its data and parity outputs read zero.

Top module: `ptx_parity_xcvr`

## Requirements
- R1: While `rst_n` is low, neither side is driven, `conflict_o` is 0 and both hold registers clear to zero. After reset, a closed latch presents all-zero data and parity.
- R2: `oe_a_n_i`=1 with `oe_b_n_i`=0 drives side B only (`b_oe_o`=1) with the A latch view. `oe_a_n_i`=0 with `oe_b_n_i`=1 drives side A only with the B latch view. The undriven side's data and parity outputs are 0.
- R3: With both output enables high, neither side is driven and both input buses can be latched and checked at once.
- R4: With both output enables low, `conflict_o` is 1 and neither side is driven.
- R5: A side latch is transparent while its enable is high. While the enable is low, it holds the value captured at the last rising clock edge with the enable high, and the bus input has no effect.
- R6: With `pass_par_i`=0, each driven parity bit is generated from its lane's latched data byte. With `odd_i`=1 the nine bits hold an odd count of ones; with `odd_i`=0 they hold an even count.
- R7: With `pass_par_i`=1, each driven parity bit equals the source latch's parity bit for that lane.
- R8: `err_a_n_o[k]` (and likewise `err_b_n_o[k]`) is 0 exactly when data bits [DW*k+DW-1:DW*k] together with parity bit k of that side's latch view fail the sense set by `odd_i`. The lanes are independent.
- R9: The flag of the receiving (driven) side is forced to all ones while that side's latch enable is low. The sending side is always checked. When neither side is driven, no flag is suppressed.
- R10: The latch of a driving side takes the driven word as its input, so a pass-through word with bad parity is flagged on both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hold registers |
| rst_n | input | 1 | Active-low reset |
| lea_i | input | 1 | Side A latch enable, transparent when high |
| leb_i | input | 1 | Side B latch enable, transparent when high |
| oe_a_n_i | input | 1 | Active-low enable for driving side A |
| oe_b_n_i | input | 1 | Active-low enable for driving side B |
| pass_par_i | input | 1 | 1 passes parity through, 0 regenerates it |
| odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| a_data_i | input | LANES*DW | Side A bus data in |
| a_par_i | input | LANES | Side A bus parity in |
| a_data_o | output | LANES*DW | Side A data driven out |
| a_par_o | output | LANES | Side A parity driven out |
| a_oe_o | output | 1 | Side A output enable |
| b_data_i | input | LANES*DW | Side B bus data in |
| b_par_i | input | LANES | Side B bus parity in |
| b_data_o | output | LANES*DW | Side B data driven out |
| b_par_o | output | LANES | Side B parity driven out |
| b_oe_o | output | 1 | Side B output enable |
| err_a_n_o | output | LANES | Side A per-lane parity error, active low |
| err_b_n_o | output | LANES | Side B per-lane parity error, active low |
| conflict_o | output | 1 | Both output enables low |

## Verification
The bench builds the block with its defaults, `LANES`=2 and `DW`=8, so each side has two lanes. The stimulus gives the two lanes opposite parity outcomes within one word, which exposes any mix-up of lane fields or flag bits. Byte patterns with odd and even counts of ones are run under both parity senses, in both directions and with latches open and closed. This covers the suppression rule on the receiving side and the readback of a pass-through word carrying bad parity.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_AB   = 2'd1,
        DIR_BA   = 2'd2,
        DIR_BAD  = 2'd3
    } dir_e;

    // Active-low enables: the side whose enable is low is driven.
    function automatic dir_e decode_dir(input logic oe_a_n, input logic oe_b_n);
        dir_e d;
        case ({oe_a_n, oe_b_n})
            2'b10:   d = DIR_AB;
            2'b01:   d = DIR_BA;
            2'b11:   d = DIR_NONE;
            default: d = DIR_BAD;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/ptx_side_latch.sv
module ptx_side_latch #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic         tx_sel,
    input  logic [W-1:0] rx_in,
    input  logic [W-1:0] tx_in,
    output logic [W-1:0] rx_view,
    output logic [W-1:0] chk_view
);

    typedef struct packed {
        logic [W-1:0] hold;
    } st_t;

    st_t          st_d, st_q;
    logic [W-1:0] din;

    always_comb begin
        din       = tx_sel ? tx_in : rx_in;
        st_d      = st_q;
        if (le) begin
            st_d.hold = din;
        end
        rx_view  = le ? rx_in : st_q.hold;
        chk_view = le ? din   : st_q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ptx_lane_par.sv
module ptx_lane_par #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] src_data,
    input  logic [DW-1:0] chk_data,
    input  logic          chk_par,
    input  logic          odd,
    output logic          gen,
    output logic          bad
);

    always_comb begin
        gen = odd ^ (^src_data);
        bad = ((^chk_data) ^ chk_par) != odd;
    end

endmodule

// File: rtl/ptx_parity_xcvr.sv
module ptx_parity_xcvr #(
    parameter int LANES = 2,
    parameter int DW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lea_i,
    input  logic                leb_i,
    input  logic                oe_a_n_i,
    input  logic                oe_b_n_i,
    input  logic                pass_par_i,
    input  logic                odd_i,
    input  logic [LANES*DW-1:0] a_data_i,
    input  logic [LANES-1:0]    a_par_i,
    output logic [LANES*DW-1:0] a_data_o,
    output logic [LANES-1:0]    a_par_o,
    output logic                a_oe_o,
    input  logic [LANES*DW-1:0] b_data_i,
    input  logic [LANES-1:0]    b_par_i,
    output logic [LANES*DW-1:0] b_data_o,
    output logic [LANES-1:0]    b_par_o,
    output logic                b_oe_o,
    output logic [LANES-1:0]    err_a_n_o,
    output logic [LANES-1:0]    err_b_n_o,
    output logic                conflict_o
);
    import ptx_pkg::*;

    localparam int DBUS = LANES * DW;
    localparam int LW   = DBUS + LANES;

    dir_e          dir;
    logic          drive_a, drive_b;
    logic [LW-1:0] a_rx, a_tx, a_rxv, a_chk;
    logic [LW-1:0] b_rx, b_tx, b_rxv, b_chk;
    logic [LANES-1:0] gen_a, gen_b, bad_a, bad_b;

    always_comb begin
        dir     = rst_n ? decode_dir(oe_a_n_i, oe_b_n_i) : DIR_NONE;
        drive_a = (dir == DIR_BA);
        drive_b = (dir == DIR_AB);
        a_rx    = {a_data_i, a_par_i};
        b_rx    = {b_data_i, b_par_i};
        a_tx    = {a_data_o, a_par_o};
        b_tx    = {b_data_o, b_par_o};
    end

    ptx_side_latch #(.W(LW)) u_latch_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .le       (lea_i),
        .tx_sel   (drive_a),
        .rx_in    (a_rx),
        .tx_in    (a_tx),
        .rx_view  (a_rxv),
        .chk_view (a_chk)
    );

    ptx_side_latch #(.W(LW)) u_latch_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .le       (leb_i),
        .tx_sel   (drive_b),
        .rx_in    (b_rx),
        .tx_in    (b_tx),
        .rx_view  (b_rxv),
        .chk_view (b_chk)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        ptx_lane_par #(.DW(DW)) u_par_a (
            .src_data (a_rxv[LANES + DW*k +: DW]),
            .chk_data (a_chk[LANES + DW*k +: DW]),
            .chk_par  (a_chk[k]),
            .odd      (odd_i),
            .gen      (gen_a[k]),
            .bad      (bad_a[k])
        );
        ptx_lane_par #(.DW(DW)) u_par_b (
            .src_data (b_rxv[LANES + DW*k +: DW]),
            .chk_data (b_chk[LANES + DW*k +: DW]),
            .chk_par  (b_chk[k]),
            .odd      (odd_i),
            .gen      (gen_b[k]),
            .bad      (bad_b[k])
        );
    end

    always_comb begin
        a_oe_o     = drive_a;
        b_oe_o     = drive_b;
        conflict_o = (dir == DIR_BAD);
        a_data_o   = drive_a ? b_rxv[LW-1:LANES] : '0;
        b_data_o   = drive_b ? a_rxv[LW-1:LANES] : '0;
        a_par_o    = drive_a ? (pass_par_i ? b_rxv[LANES-1:0] : gen_b) : '0;
        b_par_o    = drive_b ? (pass_par_i ? a_rxv[LANES-1:0] : gen_a) : '0;
        err_a_n_o  = (drive_a && !lea_i) ? '1 : ~bad_a;
        err_b_n_o  = (drive_b && !leb_i) ? '1 : ~bad_b;
    end

endmodule

// File: rtl/ptx_parity_xcvr_chk.sv
module ptx_parity_xcvr_chk #(
    parameter int LANES = 2,
    parameter int DW    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                lea_i,
    input logic                leb_i,
    input logic                pass_par_i,
    input logic                odd_i,
    input logic [LANES-1:0]    a_par_i,
    input logic [LANES-1:0]    b_par_i,
    input logic [LANES*DW-1:0] a_data_o,
    input logic [LANES-1:0]    a_par_o,
    input logic                a_oe_o,
    input logic [LANES*DW-1:0] b_data_o,
    input logic [LANES-1:0]    b_par_o,
    input logic                b_oe_o,
    input logic [LANES-1:0]    err_a_n_o,
    input logic [LANES-1:0]    err_b_n_o,
    input logic                conflict_o
);

    always_comb begin
        if (rst_n == 1'b0) begin
            AST_RESET_QUIET: assert (!a_oe_o && !b_oe_o && !conflict_o); // R1
        end
    end

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe_o && b_oe_o)); // R2

    AST_CONFLICT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_o |-> (!a_oe_o && !b_oe_o)); // R4

    AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe_o && !lea_i && $past(b_oe_o) && $past(!lea_i)) |-> $stable(b_data_o)); // R5

    AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe_o && !leb_i && $past(a_oe_o) && $past(!leb_i)) |-> $stable(a_data_o)); // R5

    AST_FEED_B: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe_o && pass_par_i && lea_i) |-> (b_par_o == a_par_i)); // R7

    AST_FEED_A: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe_o && pass_par_i && leb_i) |-> (a_par_o == b_par_i)); // R7

    AST_RX_BLOCK_B: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe_o && !leb_i) |-> (&err_b_n_o)); // R9

    AST_RX_BLOCK_A: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe_o && !lea_i) |-> (&err_a_n_o)); // R9

    for (genvar k = 0; k < LANES; k++) begin : g_gen
        AST_GEN_SENSE_B: assert property (@(posedge clk) disable iff (!rst_n)
            (b_oe_o && !pass_par_i) |-> (((^b_data_o[DW*k +: DW]) ^ b_par_o[k]) == odd_i)); // R6
        AST_GEN_SENSE_A: assert property (@(posedge clk) disable iff (!rst_n)
            (a_oe_o && !pass_par_i) |-> (((^a_data_o[DW*k +: DW]) ^ a_par_o[k]) == odd_i)); // R6
    end

endmodule

bind ptx_parity_xcvr ptx_parity_xcvr_chk #(.LANES(LANES), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lea_i      (lea_i),
    .leb_i      (leb_i),
    .pass_par_i (pass_par_i),
    .odd_i      (odd_i),
    .a_par_i    (a_par_i),
    .b_par_i    (b_par_i),
    .a_data_o   (a_data_o),
    .a_par_o    (a_par_o),
    .a_oe_o     (a_oe_o),
    .b_data_o   (b_data_o),
    .b_par_o    (b_par_o),
    .b_oe_o     (b_oe_o),
    .err_a_n_o  (err_a_n_o),
    .err_b_n_o  (err_b_n_o),
    .conflict_o (conflict_o)
);

// File: tb/ptx_parity_xcvr_test.sv
module ptx_parity_xcvr_test;

    localparam int LANES = 2;
    localparam int DW    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lea, leb, oea_n, oeb_n, pass, odd;
    logic [15:0] a_di, b_di, a_do, b_do;
    logic [1:0]  a_pi, b_pi, a_po, b_po, ea, eb;
    logic        a_oe, b_oe, cf;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ptx_parity_xcvr #(.LANES(LANES), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .lea_i(lea), .leb_i(leb),
        .oe_a_n_i(oea_n), .oe_b_n_i(oeb_n), .pass_par_i(pass), .odd_i(odd),
        .a_data_i(a_di), .a_par_i(a_pi), .a_data_o(a_do), .a_par_o(a_po), .a_oe_o(a_oe),
        .b_data_i(b_di), .b_par_i(b_pi), .b_data_o(b_do), .b_par_o(b_po), .b_oe_o(b_oe),
        .err_a_n_o(ea), .err_b_n_o(eb), .conflict_o(cf)
    );

    typedef struct {
        logic        aoe, boe, cf;
        logic [15:0] ad, bd;
        logic [1:0]  ap, bp, ea, eb;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    task automatic drive(input logic r, input logic la, input logic lb, input logic na,
                         input logic nb, input logic ps, input logic od,
                         input logic [15:0] ad, input logic [1:0] ap,
                         input logic [15:0] bd, input logic [1:0] bp);
        @(posedge clk);
        #5;
        rst_n = r; lea = la; leb = lb; oea_n = na; oeb_n = nb; pass = ps; odd = od;
        a_di = ad; a_pi = ap; b_di = bd; b_pi = bp;
    endtask

    task automatic expect_item(input logic aoe, input logic boe, input logic c,
                               input logic [15:0] ad, input logic [1:0] ap,
                               input logic [15:0] bd, input logic [1:0] bp,
                               input logic [1:0] xa, input logic [1:0] xb, input string tag);
        exp_t e;
        #5;
        e.aoe = aoe; e.boe = boe; e.cf = c; e.ad = ad; e.ap = ap;
        e.bd = bd; e.bp = bp; e.ea = xa; e.eb = xb; e.tag = tag;
        exp_q.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            wait (exp_q.size() > 0);
            e = exp_q.pop_front();
            checks++;
            if ({a_oe, b_oe, cf, a_do, a_po, b_do, b_po, ea, eb} !==
                {e.aoe, e.boe, e.cf, e.ad, e.ap, e.bd, e.bp, e.ea, e.eb}) begin
                fails++;
                $display("FAIL %s actual oe=%b%b cf=%b a=%h/%b b=%h/%b ea=%b eb=%b expected oe=%b%b cf=%b a=%h/%b b=%h/%b ea=%b eb=%b",
                         e.tag, a_oe, b_oe, cf, a_do, a_po, b_do, b_po, ea, eb,
                         e.aoe, e.boe, e.cf, e.ad, e.ap, e.bd, e.bp, e.ea, e.eb);
            end
        end
    end

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : driver
        rst_n = 1'b0; lea = 1'b1; leb = 1'b1; oea_n = 1'b1; oeb_n = 1'b0;
        pass = 1'b0; odd = 1'b0; a_di = '0; a_pi = '0; b_di = '0; b_pi = '0;
        repeat (3) @(posedge clk);
        // R1: reset keeps both sides undriven even with a direction requested
        drive(0, 1, 1, 1, 0, 0, 0, 16'h0000, 2'b00, 16'h0000, 2'b00);
        expect_item(0, 0, 0, 16'h0, 2'b00, 16'h0, 2'b00, 2'b11, 2'b11, "R1 reset quiet");
        // R1 R3: closed latches show cleared zeros, odd sense fails both lanes
        drive(1, 0, 0, 1, 1, 0, 1, 16'hFFFF, 2'b11, 16'hFFFF, 2'b11);
        expect_item(0, 0, 0, 16'h0, 2'b00, 16'h0, 2'b00, 2'b00, 2'b00, "R1 R3 cleared latches");
        // R2 R6 R8: A to B, generate, odd
        drive(1, 1, 1, 1, 0, 0, 1, 16'h0307, 2'b00, 16'h0000, 2'b00);
        expect_item(0, 1, 0, 16'h0, 2'b00, 16'h0307, 2'b10, 2'b01, 2'b11, "R2 R6 R8 gen odd");
        // R6 R8: even sense
        drive(1, 1, 1, 1, 0, 0, 0, 16'h0307, 2'b00, 16'h0000, 2'b00);
        expect_item(0, 1, 0, 16'h0, 2'b00, 16'h0307, 2'b01, 2'b10, 2'b11, "R6 R8 gen even");
        // R7 R10: pass-through of bad parity flagged on both sides
        drive(1, 1, 1, 1, 0, 1, 1, 16'h0307, 2'b01, 16'h0000, 2'b00);
        expect_item(0, 1, 0, 16'h0, 2'b00, 16'h0307, 2'b01, 2'b00, 2'b00, "R7 R10 feed bad parity");
        // R5: capture with A open
        drive(1, 1, 1, 1, 0, 0, 1, 16'h0F01, 2'b00, 16'h0000, 2'b00);
        expect_item(0, 1, 0, 16'h0, 2'b00, 16'h0F01, 2'b10, 2'b01, 2'b11, "R5 capture");
        // R5 R6: A closed, new bus input ignored, parity from latched data
        drive(1, 0, 1, 1, 0, 0, 1, 16'hFFFF, 2'b11, 16'h0000, 2'b00);
        expect_item(0, 1, 0, 16'h0, 2'b00, 16'h0F01, 2'b10, 2'b01, 2'b11, "R5 R6 hold");
        // R9: receiving B closed, its flag suppressed; sender still checked
        drive(1, 1, 0, 1, 0, 1, 1, 16'h0307, 2'b00, 16'h0000, 2'b00);
        expect_item(0, 1, 0, 16'h0, 2'b00, 16'h0307, 2'b00, 2'b01, 2'b11, "R9 B suppressed");
        // R2 R6: B to A, generate
        drive(1, 1, 1, 0, 1, 0, 1, 16'h0000, 2'b00, 16'h8001, 2'b11);
        expect_item(1, 0, 0, 16'h8001, 2'b00, 16'h0, 2'b00, 2'b11, 2'b00, "R2 R6 B to A");
        // R9: receiving A closed
        drive(1, 0, 1, 0, 1, 0, 1, 16'h5555, 2'b01, 16'h8001, 2'b11);
        expect_item(1, 0, 0, 16'h8001, 2'b00, 16'h0, 2'b00, 2'b11, 2'b00, "R9 A suppressed");
        // R3 R8: both tri-stated, both inputs checked per lane
        drive(1, 1, 1, 1, 1, 0, 1, 16'h0001, 2'b00, 16'h0300, 2'b10);
        expect_item(0, 0, 0, 16'h0, 2'b00, 16'h0, 2'b00, 2'b01, 2'b10, "R3 R8 both read");
        // R4: conflict
        drive(1, 1, 1, 0, 0, 0, 1, 16'h0001, 2'b00, 16'h0300, 2'b10);
        expect_item(0, 0, 1, 16'h0, 2'b00, 16'h0, 2'b00, 2'b01, 2'b10, "R4 conflict");
        // R5 R9: no direction, closed latches still checked on held words
        drive(1, 0, 0, 1, 1, 0, 1, 16'hFFFF, 2'b00, 16'hFFFF, 2'b00);
        expect_item(0, 0, 0, 16'h0, 2'b00, 16'h0, 2'b00, 2'b01, 2'b10, "R5 R9 held check");
        // R1: reset again mid-run
        drive(0, 1, 1, 0, 1, 0, 0, 16'h0000, 2'b00, 16'h0000, 2'b00);
        expect_item(0, 0, 0, 16'h0, 2'b00, 16'h0, 2'b00, 2'b11, 2'b11, "R1 reset again");
        #20;
        wait (exp_q.size() == 0);
        #1;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule